// File: doc/BRIEF.md
# Debug Port Data-Transfer Chains

This block is the back end of a JTAG-style debug port. It decodes which data register the debugger is working with and turns scans into moves of words to and from a halted processor. A select register, loaded under a chain-select instruction, picks one of several chains. Chain 1 is the status word, which holds two sticky abort flags and the fill state of both mailboxes. Chain 4 is the 32-bit instruction register that is fed to the processor. Chain 5 is a 34-bit data chain whose two extra bits report a Ready flag and the sticky precise abort flag.

The TAP state machine and the IR decoder stay outside. The block takes one-cycle strobes for Capture-DR, Shift-DR, Update-DR and Run-Test/Idle, plus decoded instruction flags. Each pass through Run-Test/Idle issues the held instruction to the processor, unless a precise abort is pending. A debugger reads a word by repeating an INTEST scan of chain 5 until Ready is set. It writes a word by repeating an EXTEST scan until Ready is set. The mailbox is written at Update-DR only when Ready was seen at the Capture-DR just before. A DR scan by itself never issues an instruction.

Top module: `dbg_xfer_chains`

## Requirements
- R1: On reset the select register is 0, both mailboxes are empty (`out_full`=0, `in_full`=0), both sticky abort flags are clear and `core_issue` is low.
- R2: While `ir_scan_n` is high, the chain is SEL_W bits long. Capture-DR loads the current select value and Update-DR writes the shifted value into the select register.
- R3: With select=1 and INTEST, Capture-DR loads a 32-bit status word: bit0 precise sticky, bit1 imprecise sticky, bit2 `out_full`, bit3 `in_full`, all other bits 0. The same capture clears both sticky flags. An abort arriving in that same cycle sets its flag anyway.
- R4: With select=4, Capture-DR loads the 32-bit instruction register. Update-DR writes the shifted value into it only under EXTEST; under INTEST it keeps its value.
- R5: One cycle after each `tap_idle` strobe, `core_issue` is high for exactly one cycle, with `core_instr` equal to the instruction register. A DR scan that does not pass through `tap_idle` issues nothing.
- R6: With select=5 and INTEST, Capture-DR loads {precise sticky (bit33), `out_full` (bit32), outbound word (bits 31:0)}. When `out_full` was set, this capture empties the outbound mailbox. `core_put` is accepted only while that mailbox is empty.
- R7: With select=5 and EXTEST, Capture-DR loads {precise sticky (bit33), not `in_full` (bit32), zeros (bits 31:0)}. Update-DR writes bits 31:0 into `in_data` and sets `in_full` only when bit32 was captured as 1; otherwise the shifted word is ignored. `core_take` empties the mailbox.
- R8: While the precise sticky flag is set, `tap_idle` produces no `core_issue`.
- R9: All chains shift least significant bit first: `tdo` shows bit 0 of the chain, and `tdi` enters at the top bit of the active chain length. Any other select value, or an instruction that is not INTEST, EXTEST or chain select, gives a 1-bit chain that captures 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_capture | input | 1 | Capture-DR strobe |
| tap_shift | input | 1 | Shift-DR strobe, one bit per cycle |
| tap_update | input | 1 | Update-DR strobe |
| tap_idle | input | 1 | Run-Test/Idle pass strobe |
| ir_scan_n | input | 1 | Chain-select instruction active |
| ir_intest | input | 1 | INTEST instruction active |
| ir_extest | input | 1 | EXTEST instruction active |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of chain) |
| core_issue | output | 1 | Instruction issue pulse |
| core_instr | output | DATA_W | Instruction to issue |
| core_put | input | 1 | Processor writes outbound word |
| core_put_data | input | DATA_W | Outbound word |
| out_full | output | 1 | Outbound mailbox holds a word |
| in_full | output | 1 | Inbound mailbox holds a word |
| in_data | output | DATA_W | Inbound word |
| core_take | input | 1 | Processor consumes inbound word |
| abort_precise | input | 1 | Precise abort event |
| abort_imprecise | input | 1 | Imprecise abort event |

## Verification
A vector table walks several outbound words through repeated INTEST scans of chain 5. It separates Ready-set captures, which must carry the exact word, from the empty re-scan that follows, which must report Ready clear. Write scans alternate between an empty mailbox and a full one, so an accepted update can be told from an ignored one by the value of `in_data`. Instruction scans are run with and without a pass through Run-Test/Idle and under both INTEST and EXTEST, which tells issue gating apart from register loading. Abort pulses, followed by two status reads, show the sticky clear, and bypass scans with unusual select values show the chain length.

// File: rtl/dxc_pkg.sv
package dxc_pkg;

  typedef enum logic [2:0] {
    CH_BYP  = 3'd0,
    CH_SEL  = 3'd1,
    CH_STAT = 3'd2,
    CH_ITR  = 3'd3,
    CH_DATA = 3'd4
  } chain_e;

  // number of shift stages for each chain
  function automatic int chain_len(chain_e c, int sel_w, int data_w);
    case (c)
      CH_SEL:  return sel_w;
      CH_STAT: return data_w;
      CH_ITR:  return data_w;
      CH_DATA: return data_w + 2;
      default: return 1;
    endcase
  endfunction

  // status word layout: [0] precise, [1] imprecise, [2] out_full, [3] in_full
  function automatic logic [3:0] status_bits(logic prec, logic imprec,
                                             logic ofull, logic ifull);
    return {ifull, ofull, imprec, prec};
  endfunction

endpackage

// File: rtl/dxc_shifter.sv
module dxc_shifter #(
  parameter int SR_W  = 34,
  localparam int LEN_W = $clog2(SR_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             shift,
  input  logic [SR_W-1:0]  cap_val,
  input  logic [LEN_W-1:0] len,
  input  logic             tdi,
  output logic [SR_W-1:0]  sr,
  output logic             tdo
);

  // right shift; serial input lands at bit n-1, bits at or above n cleared
  function automatic logic [SR_W-1:0] shift_in(logic [SR_W-1:0] v, logic b, int n);
    logic [SR_W-1:0] r;
    r = '0;
    for (int k = 0; k < SR_W; k++) begin
      if (k + 1 < n)       r[k] = v[k+1];
      else if (k + 1 == n) r[k] = b;
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr <= '0;
    else if (capture) sr <= cap_val;
    else if (shift)   sr <= shift_in(sr, tdi, int'(len));
  end

  assign tdo = sr[0];

endmodule

// File: rtl/dxc_sticky.sv
module dxc_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_prec,
  input  logic set_imprec,
  input  logic clr,
  output logic prec,
  output logic imprec
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prec   <= 1'b0;
      imprec <= 1'b0;
    end else begin
      if (set_prec)   prec <= 1'b1;
      else if (clr)   prec <= 1'b0;
      if (set_imprec) imprec <= 1'b1;
      else if (clr)   imprec <= 1'b0;
    end
  end

endmodule

// File: rtl/dxc_mailbox.sv
module dxc_mailbox #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_put,
  input  logic [DATA_W-1:0] core_put_data,
  input  logic              rd_cap,
  output logic              out_full,
  output logic [DATA_W-1:0] out_word,
  input  logic              wr_cap,
  input  logic              wr_upd,
  input  logic [DATA_W-1:0] upd_word,
  input  logic              core_take,
  output logic              in_full,
  output logic [DATA_W-1:0] in_word,
  output logic              wr_accept
);

  logic wr_ready_q;

  // processor to debugger direction
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_full <= 1'b0;
      out_word <= '0;
    end else if (rd_cap && out_full) begin
      out_full <= 1'b0;
    end else if (core_put && !out_full) begin
      out_full <= 1'b1;
      out_word <= core_put_data;
    end
  end

  // debugger to processor direction: ready remembered from capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wr_ready_q <= 1'b0;
    else if (wr_cap) wr_ready_q <= ~in_full;
    else if (wr_upd) wr_ready_q <= 1'b0;
  end

  assign wr_accept = wr_upd && wr_ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_full <= 1'b0;
      in_word <= '0;
    end else if (wr_accept) begin
      in_full <= 1'b1;
      in_word <= upd_word;
    end else if (core_take) begin
      in_full <= 1'b0;
    end
  end

endmodule

// File: rtl/dbg_xfer_chains.sv
module dbg_xfer_chains
  import dxc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SEL_W       = 5,
  parameter int NUM_STAT    = 1,
  parameter int NUM_ITR     = 4,
  parameter int NUM_DATA    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tap_capture,
  input  logic              tap_shift,
  input  logic              tap_update,
  input  logic              tap_idle,
  input  logic              ir_scan_n,
  input  logic              ir_intest,
  input  logic              ir_extest,
  input  logic              tdi,
  output logic              tdo,
  output logic              core_issue,
  output logic [DATA_W-1:0] core_instr,
  input  logic              core_put,
  input  logic [DATA_W-1:0] core_put_data,
  output logic              out_full,
  output logic              in_full,
  output logic [DATA_W-1:0] in_data,
  input  logic              core_take,
  input  logic              abort_precise,
  input  logic              abort_imprecise
);

  localparam int SR_W      = DATA_W + 2;
  localparam int READY_BIT = DATA_W;
  localparam int PREC_BIT  = DATA_W + 1;
  localparam int LEN_W     = $clog2(SR_W + 1);

  chain_e            chain;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] itr_q;
  logic              issue_q;
  logic [SR_W-1:0]   sr;
  logic [SR_W-1:0]   cap_val;
  logic [LEN_W-1:0]  len;
  logic              prec, imprec;
  logic [DATA_W-1:0] out_word;

  // named internal events
  logic sel_upd_fire, stat_clr_fire, itr_upd_fire;
  logic rd_cap_fire, wr_cap_fire, wr_upd_fire, wr_accept;

  always_comb begin
    chain = CH_BYP;
    if (ir_scan_n) chain = CH_SEL;
    else if (ir_intest || ir_extest) begin
      if (sel_q == SEL_W'(NUM_STAT))      chain = CH_STAT;
      else if (sel_q == SEL_W'(NUM_ITR))  chain = CH_ITR;
      else if (sel_q == SEL_W'(NUM_DATA)) chain = CH_DATA;
    end
  end

  assign sel_upd_fire  = tap_update  && (chain == CH_SEL);
  assign stat_clr_fire = tap_capture && (chain == CH_STAT) && ir_intest;
  assign itr_upd_fire  = tap_update  && (chain == CH_ITR)  && ir_extest;
  assign rd_cap_fire   = tap_capture && (chain == CH_DATA) && ir_intest;
  assign wr_cap_fire   = tap_capture && (chain == CH_DATA) && !ir_intest;
  assign wr_upd_fire   = tap_update  && (chain == CH_DATA) && !ir_intest;

  // captured value of the active chain
  always_comb begin
    cap_val = '0;
    case (chain)
      CH_SEL:  cap_val = SR_W'(sel_q);
      CH_STAT: cap_val = SR_W'(status_bits(prec, imprec, out_full, in_full));
      CH_ITR:  cap_val = SR_W'(itr_q);
      CH_DATA: begin
        cap_val[PREC_BIT]  = prec;
        cap_val[READY_BIT] = ir_intest ? out_full : ~in_full;
        cap_val[DATA_W-1:0] = ir_intest ? out_word : '0;
      end
      default: cap_val = '0;
    endcase
  end

  assign len = LEN_W'(chain_len(chain, SEL_W, DATA_W));

  dxc_shifter #(.SR_W(SR_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (tap_capture),
    .shift   (tap_shift),
    .cap_val (cap_val),
    .len     (len),
    .tdi     (tdi),
    .sr      (sr),
    .tdo     (tdo)
  );

  dxc_sticky u_sticky (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_prec   (abort_precise),
    .set_imprec (abort_imprecise),
    .clr        (stat_clr_fire),
    .prec       (prec),
    .imprec     (imprec)
  );

  dxc_mailbox #(.DATA_W(DATA_W)) u_mbox (
    .clk           (clk),
    .rst_n         (rst_n),
    .core_put      (core_put),
    .core_put_data (core_put_data),
    .rd_cap        (rd_cap_fire),
    .out_full      (out_full),
    .out_word      (out_word),
    .wr_cap        (wr_cap_fire),
    .wr_upd        (wr_upd_fire),
    .upd_word      (sr[DATA_W-1:0]),
    .core_take     (core_take),
    .in_full       (in_full),
    .in_word       (in_data),
    .wr_accept     (wr_accept)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      itr_q   <= '0;
      issue_q <= 1'b0;
    end else begin
      if (sel_upd_fire) sel_q <= sr[SEL_W-1:0];
      if (itr_upd_fire) itr_q <= sr[DATA_W-1:0];
      issue_q <= tap_idle && !prec;
    end
  end

  assign core_issue = issue_q;
  assign core_instr = itr_q;

endmodule

// File: rtl/dxc_checker.sv
module dxc_checker #(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tap_idle,
  input logic              core_issue,
  input logic              prec,
  input logic              imprec,
  input logic              abort_precise,
  input logic              abort_imprecise,
  input logic              stat_clr_fire,
  input logic              sel_upd_fire,
  input logic [SEL_W-1:0]  sel_q,
  input logic [SEL_W-1:0]  sr_low,
  input logic              itr_upd_fire,
  input logic [DATA_W-1:0] itr_q,
  input logic              rd_cap_fire,
  input logic              out_full,
  input logic              in_full,
  input logic              wr_accept
);

  p_sel_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_upd_fire |=> sel_q == $past(sr_low));

  p_status_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr_fire && !abort_precise && !abort_imprecise |=> !prec && !imprec);

  p_itr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !itr_upd_fire |=> $stable(itr_q));

  p_issue_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_issue |-> $past(tap_idle));

  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cap_fire && out_full |=> !out_full);

  p_write_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_full) |-> $past(wr_accept));

  p_no_issue_prec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_issue |-> !$past(prec));

endmodule

bind dbg_xfer_chains dxc_checker #(.DATA_W(DATA_W), .SEL_W(SEL_W)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .tap_idle        (tap_idle),
  .core_issue      (core_issue),
  .prec            (prec),
  .imprec          (imprec),
  .abort_precise   (abort_precise),
  .abort_imprecise (abort_imprecise),
  .stat_clr_fire   (stat_clr_fire),
  .sel_upd_fire    (sel_upd_fire),
  .sel_q           (sel_q),
  .sr_low          (sr[SEL_W-1:0]),
  .itr_upd_fire    (itr_upd_fire),
  .itr_q           (itr_q),
  .rd_cap_fire     (rd_cap_fire),
  .out_full        (out_full),
  .in_full         (in_full),
  .wr_accept       (wr_accept)
);

// File: tb/dbg_xfer_chains_tb.sv
`timescale 1ns/1ps
module dbg_xfer_chains_tb_top;

  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tap_capture = 0, tap_shift = 0, tap_update = 0, tap_idle = 0;
  logic ir_scan_n = 0, ir_intest = 0, ir_extest = 0, tdi = 0;
  logic tdo, core_issue, out_full, in_full;
  logic [DW-1:0] core_instr, in_data;
  logic core_put = 0, core_take = 0, abort_precise = 0, abort_imprecise = 0;
  logic [DW-1:0] core_put_data = '0;

  int checks = 0;
  int errors = 0;
  int issue_cnt = 0;
  logic [DW-1:0] issued_instr = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dbg_xfer_chains dut_i (
    .clk(clk), .rst_n(rst_n),
    .tap_capture(tap_capture), .tap_shift(tap_shift), .tap_update(tap_update),
    .tap_idle(tap_idle), .ir_scan_n(ir_scan_n), .ir_intest(ir_intest),
    .ir_extest(ir_extest), .tdi(tdi), .tdo(tdo),
    .core_issue(core_issue), .core_instr(core_instr),
    .core_put(core_put), .core_put_data(core_put_data), .out_full(out_full),
    .in_full(in_full), .in_data(in_data), .core_take(core_take),
    .abort_precise(abort_precise), .abort_imprecise(abort_imprecise)
  );

  always @(negedge clk) begin
    if (core_issue) begin
      issue_cnt    <= issue_cnt + 1;
      issued_instr <= core_instr;
    end
  end

  localparam logic [DW-1:0] RD_WORDS [4] = '{32'hDEAD_BEEF, 32'h0000_0001,
                                             32'h8000_0000, 32'h1234_5678};

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic set_ir(input logic s, input logic i, input logic e);
    @(negedge clk);
    ir_scan_n = s; ir_intest = i; ir_extest = e;
  endtask

  task automatic pulse_idle();
    @(negedge clk); tap_idle = 1;
    @(negedge clk); tap_idle = 0;
    @(negedge clk);
  endtask

  task automatic scan(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    @(negedge clk); tap_capture = 1;
    @(negedge clk); tap_capture = 0;
    for (int i = 0; i < n; i++) begin
      tap_shift = 1; tdi = din[i]; dout[i] = tdo;
      @(negedge clk);
    end
    tap_shift = 0; tap_update = 1;
    @(negedge clk); tap_update = 0;
  endtask

  task automatic select(input int ch);
    logic [63:0] d;
    set_ir(1, 0, 0);
    scan(5, 64'(ch), d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 out_full", 64'(out_full), 64'd0);
    check("R1 in_full", 64'(in_full), 64'd0);
    check("R1 core_issue", 64'(core_issue), 64'd0);
    set_ir(1, 0, 0);
    scan(5, 64'd5, d);
    check("R1 R2 select reset value", d, 64'd0);
    scan(5, 64'd5, d);
    check("R2 select readback", d, 64'd5);

    // R6 table of outbound words, each read twice
    set_ir(0, 1, 0);
    foreach (RD_WORDS[k]) begin
      @(negedge clk); core_put = 1; core_put_data = RD_WORDS[k];
      @(negedge clk); core_put = 0;
      scan(34, 64'd0, d);
      check("R6 R9 read word with ready", d, {30'd0, 2'b01, RD_WORDS[k]});
      scan(34, 64'd0, d);
      check("R6 re-read ready clear", d[33:32], 64'd0);
    end

    // R7 write path
    set_ir(0, 0, 1);
    scan(34, 64'h0_CAFE_F00D, d);
    check("R7 write capture ready", d, 64'h1_0000_0000);
    check("R7 in_full set", 64'(in_full), 64'd1);
    check("R7 in_data", 64'(in_data), 64'h CAFE_F00D);
    scan(34, 64'h0_1111_2222, d);
    check("R7 full capture not ready", d[33:32], 64'd0);
    check("R7 word ignored when not ready", 64'(in_data), 64'hCAFE_F00D);
    @(negedge clk); core_take = 1;
    @(negedge clk); core_take = 0;
    check("R7 take empties", 64'(in_full), 64'd0);

    // R4 R5 instruction register and issue
    select(4);
    set_ir(0, 0, 1);
    n0 = issue_cnt;
    scan(32, 64'hA5A5_0F0F, d);
    repeat (2) @(negedge clk);
    check("R5 no issue without idle", 64'(issue_cnt - n0), 64'd0);
    pulse_idle();
    check("R5 one issue after idle", 64'(issue_cnt - n0), 64'd1);
    check("R5 issued value", 64'(issued_instr), 64'hA5A5_0F0F);
    set_ir(0, 1, 0);
    scan(32, 64'h1234_0000, d);
    check("R4 capture of instruction", d, 64'hA5A5_0F0F);
    check("R4 intest update ignored", 64'(core_instr), 64'hA5A5_0F0F);

    // R8 R3 precise abort blocks issue until status read
    @(negedge clk); abort_precise = 1;
    @(negedge clk); abort_precise = 0;
    n0 = issue_cnt;
    pulse_idle();
    check("R8 no issue while precise sticky", 64'(issue_cnt - n0), 64'd0);
    select(5);
    set_ir(0, 1, 0);
    scan(34, 64'd0, d);
    check("R6 precise flag bit33", d[33:32], 64'd2);
    @(negedge clk); abort_imprecise = 1;
    @(negedge clk); abort_imprecise = 0;
    select(1);
    set_ir(0, 1, 0);
    scan(32, 64'd0, d);
    check("R3 status stickies", d, 64'h3);
    scan(32, 64'd0, d);
    check("R3 status cleared", d, 64'h0);
    n0 = issue_cnt;
    pulse_idle();
    check("R8 issue resumes", 64'(issue_cnt - n0), 64'd1);

    // R9 bypass chain
    select(7);
    set_ir(0, 1, 0);
    scan(2, 64'b11, d);
    check("R9 bypass one bit", d, 64'b10);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule